// File: doc/BRIEF.md
# Tick-Driven Watchdog with Periodic Timer

This block pairs a periodic down-counting timer with a watchdog controller. A single-cycle tick enable, nominally one pulse per microsecond, drives the timer. The timer reloads itself after every run down to zero, so a reload value of 1,000,000 gives a one-second period. The controller is armed with a start command. It counts timer expirations in groups of a programmable period (1 to 255). Each completed group is one watchdog expiration. The first three raise a level interrupt, and the fourth raises a sticky system reset request.

Software keeps the system alive by sending the start command again before the fourth expiration. This kick reloads the period and clears the expiration count. Stopping the watchdog takes two writes: the key 0xC45A written to the unlock word, then the disable command. The controller listens only when its source-select field names timer 5, which is the one timer built into this block.

All state sits behind a 32-bit register port with word addresses and a one-cycle registered read.

Top module: `wdt_top`

## Requirements
- R1: Register map by word address: 0 = timer control, 4 = watchdog config, 6 = command, 7 = unlock. All other words and all command/unlock reads return 0. Timer control is reload in bits [29:0], periodic in bit 30 and enable in bit 31. Config is source-select in [3:0], period in [11:4], interrupt-enable in bit 12 and reset-enable in bit 15; unimplemented config bits read 0. Read data appears one clock after the address.
- R2: With enable and periodic set and reload R ≥ 1, the timer expires once every R ticks.
- R3: With periodic clear, the timer expires once and then clears its own enable bit, which reads back as 0.
- R4: Writing 0 to timer control stops the timer, so no further expirations occur.
- R5: While running, the watchdog expires once every P timer expirations, for any period P from 1 to 255.
- R6: On the fourth watchdog expiration, with reset-enable set, sys_rst_req goes high and stays high until block reset. With reset-enable clear it never asserts.
- R7: With interrupt-enable set, irq goes high on the first watchdog expiration and stays high until a kick or a disable. With interrupt-enable clear it stays low.
- R8: A command write with bit 0 set starts or kicks the watchdog. It reloads the period and clears the expiration count and irq.
- R9: A command write with bit 1 set disables the watchdog only if the last write to the unlock word was exactly 0x0000C45A. Otherwise it is ignored.
- R10: Any command write consumes the unlock, whatever its content.
- R11: If the source-select field is not 5, the watchdog never expires.
- R12: After reset irq and sys_rst_req are low and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | Timer count enable, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for addr |
| irq | output | 1 | Level interrupt, first three expirations |
| sys_rst_req | output | 1 | Sticky reset request, fourth expiration |

## Verification
The main function is swept over every reload value from 1 to 3 combined with every period from 1 to 3, plus period 255. After each tick the bench compares irq and the reset request against floor(ticks/(R·P)). This sweep separates the timer reload from the watchdog grouping, and it shows the reset fires on the fourth expiration, not the third or fifth. Separate sequences cover one-shot and stopped timers, a mismatched source, and a kick in mid-count. Disable attempts are tried with no key, with a wrong key, with the key consumed by a prior command, and with a correct key; only the last may stop the reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_TIMER  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG    = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMD    = 3'd6;
  localparam logic [ADDR_W-1:0] A_UNLOCK = 3'd7;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_C45A;

  localparam int T_EN_BIT  = 31;
  localparam int T_PER_BIT = 30;

  localparam int C_ID_LSB  = 0;
  localparam int C_PER_LSB = 4;
  localparam int C_INT_BIT = 12;
  localparam int C_RST_BIT = 15;

  localparam int CMD_GO_BIT   = 0;
  localparam int CMD_HALT_BIT = 1;

  typedef struct packed {
    logic       rst_en;
    logic       int_en;
    logic [7:0] period;
    logic [3:0] src_id;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] tmr_word,
  output wdt_cfg_t          cfg,
  output logic              tmr_wr,
  output logic              cmd_wr,
  output logic              unlock_wr,
  output logic [DATA_W-1:0] rdata
);
  logic              cfg_wr;
  logic [DATA_W-1:0] cfg_word;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    tmr_wr    = wr_en && (addr == A_TIMER);
    cfg_wr    = wr_en && (addr == A_CFG);
    cmd_wr    = wr_en && (addr == A_CMD);
    unlock_wr = wr_en && (addr == A_UNLOCK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (cfg_wr) begin
      cfg.src_id <= wdata[C_ID_LSB +: 4];
      cfg.period <= wdata[C_PER_LSB +: 8];
      cfg.int_en <= wdata[C_INT_BIT];
      cfg.rst_en <= wdata[C_RST_BIT];
    end
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[C_ID_LSB +: 4]  = cfg.src_id;
    cfg_word[C_PER_LSB +: 8] = cfg.period;
    cfg_word[C_INT_BIT]      = cfg.int_en;
    cfg_word[C_RST_BIT]      = cfg.rst_en;
  end

  always_comb begin
    case (addr)
      A_TIMER: rd_mux = tmr_word;
      A_CFG:   rd_mux = cfg_word;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/wdt_ptimer.sv
module wdt_ptimer
  import wdt_pkg::*;
#(
  parameter int RLD_W = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word,
  output logic              expire
);
  logic             en;
  logic             periodic;
  logic [RLD_W-1:0] reload;
  logic [RLD_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt <= RLD_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      periodic <= 1'b0;
      reload   <= '0;
      cnt      <= '0;
      expire   <= 1'b0;
    end else if (wr) begin
      en       <= wdata[T_EN_BIT];
      periodic <= wdata[T_PER_BIT];
      reload   <= wdata[RLD_W-1:0];
      cnt      <= wdata[RLD_W-1:0];
      expire   <= 1'b0;
    end else if (tick && en && (reload != '0)) begin
      if (at_end) begin
        expire <= 1'b1;
        if (periodic) begin
          cnt <= reload;
        end else begin
          cnt <= '0;
          en  <= 1'b0;
        end
      end else begin
        cnt    <= cnt - RLD_W'(1);
        expire <= 1'b0;
      end
    end else begin
      expire <= 1'b0;
    end
  end

  assign rd_word = DATA_W'(reload) | ({en, periodic} << T_PER_BIT);
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int TIMER_ID  = 5,
  parameter int EXP_LIMIT = 4,
  localparam int CNT_W    = $clog2(EXP_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  wdt_cfg_t          cfg,
  input  logic              cmd_wr,
  input  logic              unlock_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic              irq,
  output logic              sys_rst,
  output logic [CNT_W-1:0]  exp_cnt,
  output logic              running,
  output logic              unlocked
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(EXP_LIMIT);

  logic [7:0]       wcnt;
  logic [CNT_W-1:0] nxt_cnt;
  logic             do_go;
  logic             do_halt;
  logic             count_en;

  always_comb begin
    do_halt  = cmd_wr && wdata[CMD_HALT_BIT] && unlocked;
    do_go    = cmd_wr && wdata[CMD_GO_BIT] && !do_halt;
    count_en = running && expire && (cfg.period != 8'd0) &&
               (cfg.src_id == 4'(TIMER_ID));
    nxt_cnt  = exp_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
    end else if (unlock_wr) begin
      unlocked <= (wdata == UNLOCK_KEY);
    end else if (cmd_wr) begin
      unlocked <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      wcnt    <= '0;
      exp_cnt <= '0;
      irq     <= 1'b0;
      sys_rst <= 1'b0;
    end else if (do_halt) begin
      running <= 1'b0;
      wcnt    <= '0;
      exp_cnt <= '0;
      irq     <= 1'b0;
    end else if (do_go) begin
      running <= 1'b1;
      wcnt    <= cfg.period;
      exp_cnt <= '0;
      irq     <= 1'b0;
    end else if (count_en) begin
      if (wcnt <= 8'd1) begin
        wcnt <= cfg.period;
        if (exp_cnt < LIM) begin
          exp_cnt <= nxt_cnt;
          if (nxt_cnt < LIM && cfg.int_en) irq <= 1'b1;
          if (nxt_cnt == LIM && cfg.rst_en) sys_rst <= 1'b1;
        end
      end else begin
        wcnt <= wcnt - 8'd1;
      end
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int RLD_W     = 30,
  parameter int TIMER_ID  = 5,
  parameter int EXP_LIMIT = 4,
  localparam int CNT_W    = $clog2(EXP_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1us,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              sys_rst_req
);
  wdt_cfg_t          cfg;
  logic              tmr_wr;
  logic              cmd_wr;
  logic              unlock_wr;
  logic [DATA_W-1:0] tmr_word;
  logic              expire;
  logic [CNT_W-1:0]  exp_cnt;
  logic              running;
  logic              unlocked;

  wdt_regif u_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .tmr_word(tmr_word), .cfg(cfg), .tmr_wr(tmr_wr), .cmd_wr(cmd_wr),
    .unlock_wr(unlock_wr), .rdata(rdata)
  );

  wdt_ptimer #(.RLD_W(RLD_W)) u_timer (
    .clk(clk), .rst(rst), .tick(tick_1us), .wr(tmr_wr), .wdata(wdata),
    .rd_word(tmr_word), .expire(expire)
  );

  wdt_ctrl #(.TIMER_ID(TIMER_ID), .EXP_LIMIT(EXP_LIMIT)) u_ctrl (
    .clk(clk), .rst(rst), .cfg(cfg), .cmd_wr(cmd_wr), .unlock_wr(unlock_wr),
    .wdata(wdata), .expire(expire), .irq(irq), .sys_rst(sys_rst_req),
    .exp_cnt(exp_cnt), .running(running), .unlocked(unlocked)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int EXP_LIMIT = 4,
  localparam int CNT_W    = $clog2(EXP_LIMIT + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_wr,
  input logic [31:0]      wdata,
  input logic             unlocked,
  input logic             running,
  input logic [CNT_W-1:0] exp_cnt,
  input logic             irq,
  input logic             sys_rst_req,
  input logic             int_en
);
  p_rst_on_fourth_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_req) |-> (exp_cnt == CNT_W'(EXP_LIMIT)));

  p_rst_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |=> sys_rst_req);

  p_irq_first_three_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (exp_cnt != '0 && exp_cnt < CNT_W'(EXP_LIMIT) && $past(int_en)));

  p_kick_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && wdata[0] && !(unlocked && wdata[1])) |=> (exp_cnt == '0 && !irq && running));

  p_halt_stops_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && wdata[1] && unlocked) |=> (!running && !irq));

  p_unlock_spent_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> !unlocked);

  p_idle_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    !running |=> $stable(exp_cnt));

  p_cnt_bounded_r6: assert property (@(posedge clk) disable iff (rst)
    exp_cnt <= CNT_W'(EXP_LIMIT));
endmodule

bind wdt_top wdt_chk #(.EXP_LIMIT(EXP_LIMIT)) u_chk (
  .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .wdata(wdata), .unlocked(unlocked),
  .running(running), .exp_cnt(exp_cnt), .irq(irq), .sys_rst_req(sys_rst_req),
  .int_en(cfg.int_en)
);

// File: tb/wdt_top_tb.sv
module wdt_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1us = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        sys_rst_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  wdt_top u_dut (
    .clk(clk), .rst(rst), .tick_1us(tick_1us), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sys_rst_req(sys_rst_req)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cyc=%0d expected <150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1us = 1'b1;
      @(negedge clk); tick_1us = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
  endtask

  function automatic logic [31:0] cfgw(input bit re, input bit ie, input int p, input int id);
    return (32'(re) << 15) | (32'(ie) << 12) | ((32'(p) & 32'hFF) << 4) | (32'(id) & 32'hF);
  endfunction

  // Arm: timer periodic reload r, watchdog period p, source 5, start.
  task automatic arm(input int r, input int p, input bit re, input bit ie);
    wr(3'd4, cfgw(re, ie, p, 5));
    wr(3'd0, 32'hC000_0000 | 32'(r));
    wr(3'd6, 32'h1);
  endtask

  task automatic sweep(input int r, input int p);
    int exp;
    do_reset();
    arm(r, p, 1'b1, 1'b1);
    for (int t = 1; t <= 4 * r * p + 1; t++) begin
      ticks(1);
      exp = t / (r * p);
      chk("R2/R5/R7 irq", 32'(irq), 32'(exp >= 1));
      chk("R6 rst on fourth", 32'(sys_rst_req), 32'(exp >= 4));
    end
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk("R12 irq", 32'(irq), 0);
    chk("R12 rst", 32'(sys_rst_req), 0);
    rd(3'd0, v); chk("R12 timer reg", v, 0);
    rd(3'd4, v); chk("R12 cfg reg", v, 0);

    // R1 register map and readback
    wr(3'd4, 32'h0000_9A35);
    rd(3'd4, v); chk("R1 cfg readback", v, 32'h0000_9A35);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); chk("R1 cfg masked", v, 32'h0000_9FFF);
    wr(3'd0, 32'hC000_0007);
    rd(3'd0, v); chk("R1 timer readback", v, 32'hC000_0007);
    rd(3'd6, v); chk("R1 cmd reads 0", v, 0);
    rd(3'd7, v); chk("R1 unlock reads 0", v, 0);
    rd(3'd2, v); chk("R1 hole reads 0", v, 0);

    // R2 R5 R6 R7 sweep
    for (int r = 1; r <= 3; r++)
      for (int p = 1; p <= 3; p++)
        sweep(r, p);
    sweep(1, 255);

    // R6/R7 enables clear: nothing asserts
    do_reset();
    arm(2, 2, 1'b0, 1'b0);
    ticks(20);
    chk("R7 irq disabled", 32'(irq), 0);
    chk("R6 rst disabled", 32'(sys_rst_req), 0);

    // R3 one-shot timer
    do_reset();
    wr(3'd4, cfgw(1, 1, 1, 5));
    wr(3'd0, 32'h8000_0001);
    wr(3'd6, 32'h1);
    ticks(3);
    chk("R3 one expiry irq", 32'(irq), 1);
    rd(3'd0, v); chk("R3 enable self-clears", v, 32'h0000_0001);
    ticks(6);
    chk("R3 no further expiry", 32'(sys_rst_req), 0);

    // R4 writing zero stops timer
    do_reset();
    arm(1, 1, 1'b1, 1'b1);
    ticks(2);
    chk("R4 running before stop", 32'(irq), 1);
    wr(3'd0, 32'h0);
    ticks(6);
    chk("R4 stopped no rst", 32'(sys_rst_req), 0);
    rd(3'd0, v); chk("R4 timer reads 0", v, 0);

    // R11 source mismatch
    do_reset();
    wr(3'd4, cfgw(1, 1, 1, 4));
    wr(3'd0, 32'hC000_0001);
    wr(3'd6, 32'h1);
    ticks(8);
    chk("R11 mismatch irq", 32'(irq), 0);
    chk("R11 mismatch rst", 32'(sys_rst_req), 0);

    // R8 kick
    do_reset();
    arm(1, 2, 1'b1, 1'b1);
    ticks(3);
    chk("R8 irq before kick", 32'(irq), 1);
    wr(3'd6, 32'h1);
    chk("R8 kick clears irq", 32'(irq), 0);
    ticks(7);
    chk("R8 three after kick no rst", 32'(sys_rst_req), 0);
    chk("R8 irq again", 32'(irq), 1);
    ticks(1);
    chk("R8 fourth after kick rst", 32'(sys_rst_req), 1);

    // R9 disable without key ignored
    do_reset();
    arm(1, 1, 1'b1, 1'b1);
    wr(3'd6, 32'h2);
    ticks(4);
    chk("R9 no key ignored", 32'(sys_rst_req), 1);

    // R9 wrong key ignored
    do_reset();
    arm(1, 1, 1'b1, 1'b1);
    wr(3'd7, 32'h0000_C45B);
    wr(3'd6, 32'h2);
    ticks(4);
    chk("R9 wrong key ignored", 32'(sys_rst_req), 1);

    // R9 correct key disables
    do_reset();
    arm(1, 1, 1'b1, 1'b1);
    ticks(1);
    wr(3'd7, 32'h0000_C45A);
    wr(3'd6, 32'h2);
    chk("R9 disable clears irq", 32'(irq), 0);
    ticks(5);
    chk("R9 disabled no irq", 32'(irq), 0);
    chk("R9 disabled no rst", 32'(sys_rst_req), 0);

    // R10 unlock consumed by any command write
    do_reset();
    arm(1, 1, 1'b1, 1'b1);
    wr(3'd7, 32'h0000_C45A);
    wr(3'd6, 32'h0);
    wr(3'd6, 32'h2);
    ticks(4);
    chk("R10 unlock consumed", 32'(sys_rst_req), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule